// File: doc/BRIEF.md
# Statistics Update Scheduler

This block decides when a statistics snapshot transfer has to be issued for one configured context. Software writes a setup through a single-cycle setup strobe. The setup carries an update policy, a statistics class, an update interval and a context id. The block checks the policy and the class, then arms itself. The counters themselves, the DMA engine and the buffer addresses belong to other blocks. This block only produces a one-cycle `trig` pulse, and the pulse carries the context id and the statistics class that the transfer engine should use.

There are three policies. In pull mode a transfer happens only when the host asks for one through `get_req`. In push mode the block also counts pulses of an external `tick_en` strobe and fires on its own every `interval` ticks. In single-shot mode the block fires exactly once, on the first tick or request after it is armed, and then disarms. A delete strobe tears the setup down. Every setup, request and delete is acknowledged one cycle later on `status_valid`, with `status_err` marking a rejected setup or a request made while nothing is armed.

Top module: `stat_sched`

## Requirements
- R1: A setup is accepted only when the mode code is 1 (pull), 2 (push) or 3 (single shot). Mode 0 or any code of 4 and above is rejected: `status_err` is 1 in the acknowledge cycle and `armed` keeps its previous value.
- R2: A setup is accepted only when the class code is 1 to 4. Class 0 or any code of 5 and above is rejected in the same way as R1.
- R3: In pull mode, `trig` rises only in the cycle after a `get_req`, and never because of `tick_en`.
- R4: In push mode with a nonzero interval N, `trig` pulses after every N-th `tick_en` strobe, counted from the accepted setup or from the last transfer.
- R5: In push mode, a `get_req` also produces a transfer one cycle later.
- R6: In push mode with interval 0, ticks never produce a transfer, but requests still do.
- R7: When a periodic expiry and a request fall in the same cycle, exactly one `trig` pulse results, and the interval count restarts from zero.
- R8: In single-shot mode, the first `tick_en` or `get_req` after arming gives one transfer. `armed` then reads 0 and later ticks give no transfer.
- R9: A `get_req` while `armed` is 0 is acknowledged with `status_err` = 1 and gives no `trig`.
- R10: `del_req` clears `armed` and is acknowledged with `status_err` = 0. It takes priority over a setup or a request in the same cycle.
- R11: Every `trig` pulse carries the context id and the class code of the setup that is currently accepted.
- R12: After reset, `armed`, `trig`, `status_valid` and `status_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Interval time base strobe |
| setup_valid | input | 1 | Setup write strobe |
| setup_mode | input | MODE_W | Update policy code |
| setup_type | input | TYPE_W | Statistics class code |
| setup_ivl | input | IVL_W | Push interval in ticks, 0 means no periodic transfers |
| setup_ctx | input | CTX_W | Context id |
| get_req | input | 1 | Explicit host request for a transfer |
| del_req | input | 1 | Tear the setup down |
| trig | output | 1 | One-cycle transfer trigger |
| trig_ctx | output | CTX_W | Context id for the transfer |
| trig_type | output | TYPE_W | Statistics class for the transfer |
| armed | output | 1 | A setup is active |
| status_valid | output | 1 | Acknowledge of setup, request or delete |
| status_err | output | 1 | The acknowledged operation was rejected |

## Verification
The bench builds the block with 4-bit mode and class fields, an 8-bit context id and a 4-bit interval. The 4-bit code fields let the bench drive out-of-range codes such as 4, 5 and 15 and see them rejected. The narrow interval puts the largest interval, 15 ticks, within a short run, so the wrap of the interval counter at full scale is exercised next to the small intervals and the zero case.

// File: rtl/stat_sched_pkg.sv
package stat_sched_pkg;

   typedef enum logic [1:0] {
      SM_OFF    = 2'd0,
      SM_PULL   = 2'd1,
      SM_PUSH   = 2'd2,
      SM_SINGLE = 2'd3
   } sched_mode_e;

   localparam int unsigned MODE_MAX_CODE = 3;
   localparam int unsigned TYPE_MAX_CODE = 4;

endpackage

// File: rtl/stat_cfg_check.sv
module stat_cfg_check
   import stat_sched_pkg::*;
#(
   parameter int unsigned MODE_W = 4,
   parameter int unsigned TYPE_W = 4
) (
   input  logic [MODE_W-1:0] mode_i,
   input  logic [TYPE_W-1:0] type_i,
   output logic              ok_o,
   output sched_mode_e       mode_o
);

   localparam logic [MODE_W-1:0] MODE_TOP = MODE_W'(MODE_MAX_CODE);
   localparam logic [TYPE_W-1:0] TYPE_TOP = TYPE_W'(TYPE_MAX_CODE);

   generate
      if (MODE_W < 2) begin : g_mode_w_bad
         $error("stat_cfg_check: MODE_W must hold code 3");
      end
      if (TYPE_W < 3) begin : g_type_w_bad
         $error("stat_cfg_check: TYPE_W must hold code 4");
      end
   endgenerate

   logic mode_ok, type_ok;

   always_comb begin
      mode_ok = (mode_i != '0) && (mode_i <= MODE_TOP);
      type_ok = (type_i != '0) && (type_i <= TYPE_TOP);
      ok_o    = mode_ok && type_ok;
      mode_o  = mode_ok ? sched_mode_e'(mode_i[1:0]) : SM_OFF;
   end

endmodule

// File: rtl/stat_ivl_timer.sv
module stat_ivl_timer #(
   parameter int unsigned IVL_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic             restart_i,
   input  logic [IVL_W-1:0] ivl_i,
   output logic             expire_o
);

   generate
      if (IVL_W < 1) begin : g_ivl_w_bad
         $error("stat_ivl_timer: IVL_W must be at least 1");
      end
   endgenerate

   logic [IVL_W-1:0] cnt_q;

   assign expire_o = run_i && tick_i && (cnt_q == ivl_i - IVL_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart_i || !run_i)
         cnt_q <= '0;
      else if (tick_i)
         cnt_q <= cnt_q + IVL_W'(1);
   end

   // R4
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && $past(run_i) && $stable(ivl_i)) |-> (cnt_q < ivl_i));

endmodule

// File: rtl/stat_sched.sv
module stat_sched
   import stat_sched_pkg::*;
#(
   parameter int unsigned MODE_W = 4,
   parameter int unsigned TYPE_W = 4,
   parameter int unsigned CTX_W  = 16,
   parameter int unsigned IVL_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              setup_valid,
   input  logic [MODE_W-1:0] setup_mode,
   input  logic [TYPE_W-1:0] setup_type,
   input  logic [IVL_W-1:0]  setup_ivl,
   input  logic [CTX_W-1:0]  setup_ctx,
   input  logic              get_req,
   input  logic              del_req,
   output logic              trig,
   output logic [CTX_W-1:0]  trig_ctx,
   output logic [TYPE_W-1:0] trig_type,
   output logic              armed,
   output logic              status_valid,
   output logic              status_err
);

   logic              cfg_ok;
   sched_mode_e       cfg_mode;
   sched_mode_e       mode_q;
   logic [TYPE_W-1:0] type_q;
   logic [CTX_W-1:0]  ctx_q;
   logic [IVL_W-1:0]  ivl_q;
   logic              armed_q;

   logic setup_ok, setup_bad, quiet, get_ok, get_bad;
   logic run_push, expire, per_fire, ss_fire, fire;

   stat_cfg_check #(.MODE_W(MODE_W), .TYPE_W(TYPE_W)) i_check (
      .mode_i (setup_mode),
      .type_i (setup_type),
      .ok_o   (cfg_ok),
      .mode_o (cfg_mode)
   );

   always_comb begin
      quiet     = !del_req && !setup_valid;
      setup_ok  = setup_valid && !del_req && cfg_ok;
      setup_bad = setup_valid && !del_req && !cfg_ok;
      get_ok    = get_req && quiet && armed_q;
      get_bad   = get_req && quiet && !armed_q;
      run_push  = armed_q && (mode_q == SM_PUSH) && (ivl_q != '0);
      per_fire  = expire && quiet;
      ss_fire   = armed_q && (mode_q == SM_SINGLE) && tick_en && quiet;
      fire      = get_ok || per_fire || ss_fire;
   end

   stat_ivl_timer #(.IVL_W(IVL_W)) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_push),
      .tick_i    (tick_en),
      .restart_i (setup_ok || fire || expire),
      .ivl_i     (ivl_q),
      .expire_o  (expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         mode_q  <= SM_OFF;
         type_q  <= '0;
         ctx_q   <= '0;
         ivl_q   <= '0;
      end else if (del_req) begin
         armed_q <= 1'b0;
      end else if (setup_ok) begin
         armed_q <= 1'b1;
         mode_q  <= cfg_mode;
         type_q  <= setup_type;
         ctx_q   <= setup_ctx;
         ivl_q   <= setup_ivl;
      end else if (fire && (mode_q == SM_SINGLE)) begin
         armed_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trig         <= 1'b0;
         trig_ctx     <= '0;
         trig_type    <= '0;
         status_valid <= 1'b0;
         status_err   <= 1'b0;
      end else begin
         trig         <= fire;
         if (fire) begin
            trig_ctx  <= ctx_q;
            trig_type <= type_q;
         end
         status_valid <= setup_valid || get_req || del_req;
         status_err   <= setup_bad || get_bad;
      end
   end

   assign armed = armed_q;

   // R1 R2
   bad_setup_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_valid && !del_req && !cfg_ok) |=> (status_err && (armed == $past(armed_q))));

   // R3
   pull_no_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && (mode_q == SM_PULL) && !get_req) |=> !trig);

   // R8
   single_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && (mode_q == SM_SINGLE)) |-> !armed);

   // R9
   unarmed_get_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (get_req && !armed && !del_req && !setup_valid) |=> (status_err && !trig));

   // R10
   delete_chk: assert property (@(posedge clk) disable iff (!rst_n)
      del_req |=> (!armed && !trig && !status_err));

endmodule

// File: tb/test_stat_sched.sv
module test_stat_sched;

   localparam int unsigned MODE_W = 4;
   localparam int unsigned TYPE_W = 4;
   localparam int unsigned CTX_W  = 8;
   localparam int unsigned IVL_W  = 4;
   localparam time CLK_PERIOD = 10ns;

   typedef struct packed {
      logic [3:0] mode;
      logic [3:0] typ;
      logic       bad;
   } vec_t;

   localparam int NVEC = 9;
   localparam vec_t VECS [NVEC] = '{
      '{4'd1,  4'd1,  1'b0},
      '{4'd2,  4'd4,  1'b0},
      '{4'd3,  4'd2,  1'b0},
      '{4'd0,  4'd1,  1'b1},
      '{4'd4,  4'd1,  1'b1},
      '{4'd15, 4'd3,  1'b1},
      '{4'd1,  4'd0,  1'b1},
      '{4'd2,  4'd5,  1'b1},
      '{4'd3,  4'd15, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_en = 1'b0;
   logic setup_valid = 1'b0;
   logic [MODE_W-1:0] setup_mode = '0;
   logic [TYPE_W-1:0] setup_type = '0;
   logic [IVL_W-1:0]  setup_ivl = '0;
   logic [CTX_W-1:0]  setup_ctx = '0;
   logic get_req = 1'b0;
   logic del_req = 1'b0;
   logic trig, armed, status_valid, status_err;
   logic [CTX_W-1:0]  trig_ctx;
   logic [TYPE_W-1:0] trig_type;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stat_sched #(.MODE_W(MODE_W), .TYPE_W(TYPE_W), .CTX_W(CTX_W), .IVL_W(IVL_W)) i_stat_sched (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .setup_valid(setup_valid), .setup_mode(setup_mode), .setup_type(setup_type),
      .setup_ivl(setup_ivl), .setup_ctx(setup_ctx),
      .get_req(get_req), .del_req(del_req),
      .trig(trig), .trig_ctx(trig_ctx), .trig_type(trig_type),
      .armed(armed), .status_valid(status_valid), .status_err(status_err)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      setup_valid = 1'b0;
      get_req = 1'b0;
      del_req = 1'b0;
      tick_en = 1'b0;
   endtask

   task automatic do_setup(input int m, input int t, input int ivl, input int ctx);
      setup_valid = 1'b1;
      setup_mode = MODE_W'(m);
      setup_type = TYPE_W'(t);
      setup_ivl = IVL_W'(ivl);
      setup_ctx = CTX_W'(ctx);
      cyc();
   endtask

   task automatic do_del();
      del_req = 1'b1;
      cyc();
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R12 reset state
      check("R12 armed", int'(armed), 0);
      check("R12 trig", int'(trig), 0);
      check("R12 status_valid", int'(status_valid), 0);
      check("R12 status_err", int'(status_err), 0);
      rst_n = 1'b1;
      cyc();

      // R1 R2 table of setup codes
      for (int i = 0; i < NVEC; i++) begin
         do_del();
         do_setup(int'(VECS[i].mode), int'(VECS[i].typ), 2, 9);
         check(VECS[i].bad ? "R1/R2 reject err" : "R1/R2 accept err", int'(status_err), int'(VECS[i].bad));
         check("R1/R2 status_valid", int'(status_valid), 1);
         check("R1/R2 armed", int'(armed), int'(!VECS[i].bad));
      end

      // R1 rejected setup keeps an armed state
      do_setup(1, 3, 0, 7);
      do_setup(4, 3, 0, 8);
      check("R1 armed kept", int'(armed), 1);

      // R3 pull: ticks do nothing, request fires
      do_setup(1, 3, 2, 33);
      for (int i = 0; i < 5; i++) begin
         tick_en = 1'b1;
         cyc();
         check("R3 no auto", int'(trig), 0);
      end
      get_req = 1'b1;
      cyc();
      check("R3 get trig", int'(trig), 1);
      check("R11 ctx", int'(trig_ctx), 33);
      check("R11 type", int'(trig_type), 3);
      cyc();
      check("R3 single pulse", int'(trig), 0);

      // R4 push interval 3
      do_setup(2, 1, 3, 44);
      for (int i = 0; i < 6; i++) begin
         tick_en = 1'b1;
         cyc();
         check("R4 periodic", int'(trig), (i % 3 == 2) ? 1 : 0);
      end
      check("R11 push ctx", int'(trig_ctx), 44);
      // R7 coincidence: two ticks, then tick plus request
      tick_en = 1'b1; cyc();
      tick_en = 1'b1; cyc();
      tick_en = 1'b1; get_req = 1'b1; cyc();
      check("R7 one pulse", int'(trig), 1);
      for (int i = 0; i < 3; i++) begin
         tick_en = 1'b1;
         cyc();
         check("R7 restart", int'(trig), (i == 2) ? 1 : 0);
      end
      // R5 request between ticks
      get_req = 1'b1;
      cyc();
      check("R5 push get", int'(trig), 1);

      // R6 interval zero
      do_setup(2, 2, 0, 55);
      for (int i = 0; i < 20; i++) begin
         tick_en = 1'b1;
         cyc();
         check("R6 no periodic", int'(trig), 0);
      end
      get_req = 1'b1;
      cyc();
      check("R6 get still fires", int'(trig), 1);

      // R4 full-scale interval 15
      do_setup(2, 4, 15, 66);
      for (int i = 0; i < 16; i++) begin
         tick_en = 1'b1;
         cyc();
         check("R4 ivl 15", int'(trig), (i == 14) ? 1 : 0);
      end

      // R8 single shot on tick
      do_setup(3, 2, 5, 77);
      tick_en = 1'b1;
      cyc();
      check("R8 fires", int'(trig), 1);
      check("R8 disarmed", int'(armed), 0);
      check("R11 single ctx", int'(trig_ctx), 77);
      tick_en = 1'b1;
      cyc();
      check("R8 once only", int'(trig), 0);
      // R9 request after disarm
      get_req = 1'b1;
      cyc();
      check("R9 err", int'(status_err), 1);
      check("R9 no trig", int'(trig), 0);

      // R8 single shot on request
      do_setup(3, 4, 0, 88);
      get_req = 1'b1;
      cyc();
      check("R8 get fires", int'(trig), 1);
      check("R8 get disarms", int'(armed), 0);

      // R10 delete then request
      do_setup(1, 1, 0, 99);
      del_req = 1'b1;
      cyc();
      check("R10 disarmed", int'(armed), 0);
      check("R10 no err", int'(status_err), 0);
      get_req = 1'b1;
      cyc();
      check("R10 get err", int'(status_err), 1);
      check("R10 no trig", int'(trig), 0);

      // R10 delete wins over a request in the same cycle
      do_setup(1, 1, 0, 12);
      del_req = 1'b1;
      get_req = 1'b1;
      cyc();
      check("R10 priority trig", int'(trig), 0);
      check("R10 priority armed", int'(armed), 0);

      finish_run();
   end

endmodule